// File: doc/BRIEF.md
# Up/Down Trimmer Wiper Controller

This block is the digital control part of a sixteen-position trimmer. A host drives three pins: an active-low select, a step strobe that acts on its falling edge, and a direction level. While selected, every falling edge of the strobe moves a saturating wiper position by one tap, up or down. The position is decoded onto a one-hot tap-select bus that drives the analog switch array.

When the host deselects the block, the strobe level at that moment decides what happens. With the strobe high, the position is committed to a retained register and a timed store cycle runs with `busy_o` high. With the strobe low, nothing is written and the block drops straight to standby. The retained register is cleared to a parameterised default only by power-on reset. Both power-on reset and soft reset reload the working position from it. All three pins are asynchronous and pass through a synchroniser.

The controller is built around four named states. `ST_LOAD` copies the retained value into the wiper and always moves on to `ST_STANDBY`. `ST_STANDBY` goes to `ST_ACTIVE` when a new selection arrives, meaning select is seen falling. `ST_ACTIVE` takes steps until deselect. It then goes to `ST_STORE` if the strobe is high, or back to `ST_STANDBY` if the strobe is low. `ST_STORE` returns to `ST_STANDBY` when its timer expires. A soft reset from any state leads to `ST_LOAD`.

Top module: `trim_wiper_ctrl`

## Requirements
- R1: `tap_sel` has exactly one bit set, and that bit is bit number `pos_o` (bit 0 is tap 0, bit TAPS-1 is the top tap).
- R2: Strobe edges that arrive while no selection is active leave the position unchanged.
- R3: While active, each falling edge of `stb` moves `pos_o` up by one when `dir_up` is 1 and down by one when it is 0. The move shows within four clock cycles of the pin edge (two synchroniser flops plus the position register).
- R4: The position saturates. A down step at 0 and an up step at TAPS-1 leave it unchanged.
- R5: `dir_up` may change while selected, and later steps follow the new direction.
- R6: Deselecting (`sel_n` rising) while `stb` is high commits the position to the retained register. `busy_o` is then high for exactly STORE_CYCLES clocks, after which `standby_o` is high.
- R7: Deselecting while `stb` is low writes nothing, enters standby at once without asserting `busy_o`, and keeps the working position.
- R8: During a store cycle, steps and a new selection are ignored. A selection still held low when the store ends does not activate the block until select is released and asserted again.
- R9: Power-on reset (`por_n` low) sets the retained register to NV_DEFAULT, and the wiper then starts at that value.
- R10: A soft reset (`srst` high for one clock) reloads the position from the retained register and leaves the register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| srst | input | 1 | Synchronous soft reset, active high |
| sel_n | input | 1 | Select pin, active low, asynchronous |
| stb | input | 1 | Step strobe, falling edge active, asynchronous |
| dir_up | input | 1 | Step direction: 1 up, 0 down |
| tap_sel | output | TAPS | One-hot tap select |
| pos_o | output | $clog2(TAPS) | Wiper position |
| busy_o | output | 1 | Store cycle in progress |
| standby_o | output | 1 | Idle, waiting for a new selection |

## Verification
The hardest case to reach from the ports is a step or a re-selection that lands inside a store cycle. Only a deselect with the strobe high opens that window, and the window closes after a fixed number of clocks. The stimulus commits a position, waits until `busy_o` is seen high, and then pulls select low and strobes twice well within the store length. It holds select low past the end of the store, so the rule that only a fresh selection activates the block is exercised. The committed value is then read back by soft reset, and a deselect with the strobe low is shown not to overwrite it.

// File: rtl/twpot_pkg.sv
package twpot_pkg;
    typedef enum logic [1:0] {
        ST_LOAD    = 2'd0,
        ST_STANDBY = 2'd1,
        ST_ACTIVE  = 2'd2,
        ST_STORE   = 2'd3
    } wstate_e;
endpackage

// File: rtl/twpot_sync.sv
module twpot_sync #(
    parameter int unsigned     WIDTH   = 3,
    parameter int unsigned     STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [STAGES-1:0][WIDTH-1:0] stage_q;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            stage_q <= {STAGES{RST_VAL}};
        end else begin
            stage_q <= {stage_q[STAGES-2:0], async_i};
        end
    end

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/twpot_counter.sv
module twpot_counter #(
    parameter int unsigned      POS_W   = 4,
    parameter logic [POS_W-1:0] MAX_POS = '1,
    parameter logic [POS_W-1:0] RST_POS = '0
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             load_i,
    input  logic [POS_W-1:0] load_val_i,
    input  logic             step_i,
    input  logic             up_i,
    output logic [POS_W-1:0] pos_o
);
    logic [POS_W-1:0] pos_q;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            pos_q <= RST_POS;
        end else if (load_i) begin
            pos_q <= load_val_i;
        end else if (step_i) begin
            if (up_i && (pos_q != MAX_POS)) begin
                pos_q <= pos_q + 1'b1;
            end else if (!up_i && (pos_q != '0)) begin
                pos_q <= pos_q - 1'b1;
            end
        end
    end

    assign pos_o = pos_q;

    // R4
    sat_top_chk: assert property (@(posedge clk) disable iff (!por_n)
        (step_i && up_i && !load_i && pos_q == MAX_POS) |=> (pos_q == MAX_POS));
    // R4
    sat_bot_chk: assert property (@(posedge clk) disable iff (!por_n)
        (step_i && !up_i && !load_i && pos_q == '0) |=> (pos_q == '0));
    // R3
    step_up_chk: assert property (@(posedge clk) disable iff (!por_n)
        (step_i && up_i && !load_i && pos_q != MAX_POS) |=> (pos_q == $past(pos_q) + 1'b1));
    // R3
    step_dn_chk: assert property (@(posedge clk) disable iff (!por_n)
        (step_i && !up_i && !load_i && pos_q != '0) |=> (pos_q == $past(pos_q) - 1'b1));
endmodule

// File: rtl/twpot_decode.sv
module twpot_decode #(
    parameter int unsigned TAPS  = 16,
    parameter int unsigned POS_W = 4
) (
    input  logic [POS_W-1:0] pos_i,
    output logic [TAPS-1:0]  tap_o
);
    for (genvar t = 0; t < TAPS; t++) begin : g_tap
        assign tap_o[t] = (pos_i == POS_W'(t));
    end
endmodule

// File: rtl/trim_wiper_ctrl.sv
module trim_wiper_ctrl
    import twpot_pkg::*;
#(
    parameter int unsigned TAPS         = 16,
    parameter int unsigned STORE_CYCLES = 1_000_000,
    parameter int unsigned NV_DEFAULT   = 0,
    parameter int unsigned SYNC_STAGES  = 2
) (
    input  logic                     clk,
    input  logic                     por_n,
    input  logic                     srst,
    input  logic                     sel_n,
    input  logic                     stb,
    input  logic                     dir_up,
    output logic [TAPS-1:0]          tap_sel,
    output logic [$clog2(TAPS)-1:0]  pos_o,
    output logic                     busy_o,
    output logic                     standby_o
);
    localparam int unsigned      POS_W   = $clog2(TAPS);
    localparam int unsigned      TMR_W   = $clog2(STORE_CYCLES + 1);
    localparam logic [POS_W-1:0] MAX_POS = POS_W'(TAPS - 1);
    localparam logic [POS_W-1:0] DEF_POS = POS_W'(NV_DEFAULT);

    logic             sel_s, stb_s, dir_s;
    logic             sel_prev_q, stb_prev_q;
    logic             stb_fall, sel_fall;
    wstate_e          state_q, state_d;
    logic [POS_W-1:0] pos_q;
    logic [POS_W-1:0] nv_q;
    logic [TMR_W-1:0] tmr_q;
    logic             step_en, commit, tmr_load, load_pos;

    twpot_sync #(
        .WIDTH  (3),
        .STAGES (SYNC_STAGES),
        .RST_VAL(3'b011)
    ) u_sync (
        .clk    (clk),
        .por_n  (por_n),
        .async_i({dir_up, stb, sel_n}),
        .sync_o ({dir_s, stb_s, sel_s})
    );

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            sel_prev_q <= 1'b1;
            stb_prev_q <= 1'b1;
        end else begin
            sel_prev_q <= sel_s;
            stb_prev_q <= stb_s;
        end
    end

    assign stb_fall = stb_prev_q & ~stb_s;
    assign sel_fall = sel_prev_q & ~sel_s;

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (srst) begin
            state_d = ST_LOAD;
        end else begin
            unique case (state_q)
                ST_LOAD:    state_d = ST_STANDBY;
                ST_STANDBY: if (sel_fall) state_d = ST_ACTIVE;
                ST_ACTIVE:  if (sel_s) state_d = stb_s ? ST_STORE : ST_STANDBY;
                ST_STORE:   if (tmr_q == '0) state_d = ST_STANDBY;
                default:    state_d = ST_LOAD;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            state_q <= ST_LOAD;
        end else begin
            state_q <= state_d;
        end
    end

    // outputs and controls
    always_comb begin
        step_en   = 1'b0;
        commit    = 1'b0;
        tmr_load  = 1'b0;
        load_pos  = 1'b0;
        busy_o    = 1'b0;
        standby_o = 1'b0;
        unique case (state_q)
            ST_LOAD:    load_pos  = !srst;
            ST_STANDBY: standby_o = 1'b1;
            ST_ACTIVE: begin
                step_en  = !srst && !sel_s && stb_fall;
                commit   = !srst && sel_s && stb_s;
                tmr_load = commit;
            end
            ST_STORE:   busy_o = 1'b1;
            default:    ;
        endcase
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            nv_q <= DEF_POS;
        end else if (commit) begin
            nv_q <= pos_q;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            tmr_q <= '0;
        end else if (tmr_load) begin
            tmr_q <= TMR_W'(STORE_CYCLES - 1);
        end else if (state_q == ST_STORE && tmr_q != '0) begin
            tmr_q <= tmr_q - 1'b1;
        end
    end

    twpot_counter #(
        .POS_W  (POS_W),
        .MAX_POS(MAX_POS),
        .RST_POS(DEF_POS)
    ) u_cnt (
        .clk       (clk),
        .por_n     (por_n),
        .load_i    (load_pos),
        .load_val_i(nv_q),
        .step_i    (step_en),
        .up_i      (dir_s),
        .pos_o     (pos_q)
    );

    twpot_decode #(
        .TAPS (TAPS),
        .POS_W(POS_W)
    ) u_dec (
        .pos_i(pos_q),
        .tap_o(tap_sel)
    );

    assign pos_o = pos_q;

    // R1
    tap_onehot_chk: assert property (@(posedge clk) disable iff (!por_n)
        ($countones(tap_sel) == 1));
    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
        (state_q == ST_STANDBY && !srst) |=> $stable(pos_q));
    // R8
    store_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
        (state_q == ST_STORE && !srst) |=> $stable(pos_q));
    // R7
    nv_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
        (state_q != ST_ACTIVE || !sel_s || !stb_s) |=> $stable(nv_q));
    // R6
    store_end_chk: assert property (@(posedge clk) disable iff (!por_n)
        (state_q == ST_STORE && tmr_q == '0 && !srst) |=> (state_q == ST_STANDBY));
endmodule

// File: tb/trim_wiper_ctrl_tb.sv
`timescale 1ns/100ps
module trim_wiper_ctrl_tb;
    localparam int TAPS = 16;
    localparam int SC   = 40;
    localparam int DEF  = 0;

    logic clk = 1'b0;
    logic por_n = 1'b0;
    logic srst = 1'b0;
    logic sel_n = 1'b1;
    logic stb = 1'b1;
    logic dir_up = 1'b0;
    logic [TAPS-1:0] tap_sel;
    logic [3:0]      pos_o;
    logic            busy_o, standby_o;

    int nchk = 0;
    int nerr = 0;

    always #2.5 clk = ~clk;

    trim_wiper_ctrl #(.TAPS(TAPS), .STORE_CYCLES(SC), .NV_DEFAULT(DEF)) u_dut (
        .clk(clk), .por_n(por_n), .srst(srst), .sel_n(sel_n), .stb(stb),
        .dir_up(dir_up), .tap_sel(tap_sel), .pos_o(pos_o),
        .busy_o(busy_o), .standby_o(standby_o)
    );

    task automatic chk(input string tag, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // behavioural reference: 0 load, 1 standby, 2 active, 3 store
    int m_st = 0, m_pos = DEF, m_nv = DEF, m_tmr = 0;
    bit a_sel = 1, b_sel = 1, a_stb = 1, b_stb = 1, a_dir = 0, b_dir = 0;
    bit p_stb = 1, p_sel = 1;

    always @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            m_st = 0; m_pos = DEF; m_nv = DEF; m_tmr = 0;
            a_sel = 1; b_sel = 1; a_stb = 1; b_stb = 1; a_dir = 0; b_dir = 0;
            p_stb = 1; p_sel = 1;
        end else begin
            if (srst) m_st = 0;
            else if (m_st == 0) begin m_pos = m_nv; m_st = 1; end
            else if (m_st == 1) begin if (p_sel && !b_sel) m_st = 2; end
            else if (m_st == 2) begin
                if (b_sel) begin
                    if (b_stb) begin m_nv = m_pos; m_tmr = SC - 1; m_st = 3; end
                    else m_st = 1;
                end else if (p_stb && !b_stb) begin
                    if (b_dir && m_pos < TAPS - 1) m_pos++;
                    else if (!b_dir && m_pos > 0) m_pos--;
                end
            end else begin
                if (m_tmr == 0) m_st = 1; else m_tmr--;
            end
            p_stb = b_stb; p_sel = b_sel;
            b_sel = a_sel; b_stb = a_stb; b_dir = a_dir;
            a_sel = sel_n; a_stb = stb; a_dir = dir_up;
        end
    end

    always @(posedge clk) begin
        #2;
        chk("R3 model pos", pos_o, m_pos);
        chk("R1 model tap", tap_sel, 1 << m_pos);
        chk("R6 model busy", busy_o, m_st == 3);
        chk("R7 model standby", standby_o, m_st == 1);
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask
    task automatic step();
        stb = 1'b0; idle(4); stb = 1'b1; idle(4);
    endtask
    task automatic soft_reset();
        srst = 1'b1; idle(1); srst = 1'b0; idle(4);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        idle(3); por_n = 1'b1; idle(4);
        chk("R9 reset pos", pos_o, DEF);
        chk("R1 reset tap", tap_sel, 1);
        chk("R9 reset standby", standby_o, 1);
        chk("R9 reset busy", busy_o, 0);

        sel_n = 1'b0; idle(4); dir_up = 1'b1;
        repeat (3) step();
        chk("R3 up x3", pos_o, 3);
        chk("R1 tap at 3", tap_sel, 16'h0008);
        dir_up = 1'b0; step();
        chk("R5 down after up", pos_o, 2);

        stb = 1'b0; idle(4);            // falling edge steps down to 1
        sel_n = 1'b1; idle(4);
        chk("R7 no-store standby", standby_o, 1);
        chk("R7 no-store busy", busy_o, 0);
        chk("R7 position kept", pos_o, 1);
        stb = 1'b1; idle(4);
        soft_reset();
        chk("R10 reload default (R7 no write)", pos_o, DEF);

        dir_up = 1'b1; step(); step();
        chk("R2 deselected steps ignored", pos_o, DEF);

        sel_n = 1'b0; idle(4);
        dir_up = 1'b0; step();
        chk("R4 floor", pos_o, 0);
        dir_up = 1'b1; repeat (20) step();
        chk("R4 ceiling", pos_o, 15);
        dir_up = 1'b0; repeat (6) step();
        chk("R5 down to 9", pos_o, 9);

        sel_n = 1'b1;
        begin
            int n = 0;
            repeat (200) begin @(negedge clk); if (busy_o) n++; end
            chk("R6 busy length", n, SC);
        end
        chk("R6 standby after store", standby_o, 1);
        soft_reset();
        chk("R6 committed 9 (R10)", pos_o, 9);

        sel_n = 1'b0; idle(4); dir_up = 1'b1; step();
        chk("R3 up to 10", pos_o, 10);
        sel_n = 1'b1; idle(4);
        chk("R6 busy seen", busy_o, 1);
        sel_n = 1'b0; step(); step();
        chk("R8 steps during store ignored", pos_o, 10);
        chk("R8 still busy", busy_o, 1);
        idle(40);
        chk("R8 held select not active", standby_o, 1);
        step();
        chk("R8 step after store ignored", pos_o, 10);
        sel_n = 1'b1; idle(4); sel_n = 1'b0; idle(4);
        step();
        chk("R3 fresh selection steps", pos_o, 11);
        stb = 1'b0; idle(4); sel_n = 1'b1; idle(4);
        chk("R7 pos after low deselect", pos_o, 12);
        stb = 1'b1; idle(4);
        soft_reset();
        chk("R10 reload keeps stored 10", pos_o, 10);

        por_n = 1'b0; idle(2); por_n = 1'b1; idle(4);
        chk("R9 power-on default", pos_o, DEF);

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule